// File: doc/BRIEF.md
# Timer-Paced Serial Shift Port

This block is the serial shifter of a peripheral interface: an eight-bit register that moves one byte at a time through a clock pin and a data pin. Its bit rate is set by a down-counter that reloads from a programmable rate byte. Each time the counter runs out, the clock pin changes level. A bit therefore spans two of these events, and a whole byte spans sixteen.

A processor programs the block through a small register port. It sets the rate byte, then writes a mode byte that picks receive or transmit. A read or write of the data register starts a transfer. In transmit mode the byte leaves MSB first and is rotated back into the register, so the register holds its original value once the byte is done. In receive mode the data pin is sampled into the LSB. When eight bits have moved, a completion flag is raised and the clock pin rests high. The flag can be routed to an interrupt line through an enable bit.

Top module: `timed_shift_port`

## Requirements
- R1: Register addresses: 0 data, 1 rate, 2 mode, 3 flag, 4 enable. Mode bits [4:2] select the function: 3'b001 receives and 3'b101 transmits. Bit 4 gives the direction (1 means transmit). Any other value leaves the shifter idle, with no clock edges. clk_pin_oe is high in both active modes. dat_pin_oe is high only in transmit mode.
- R2: With rate value N, the clock pin changes level every N+2 system clocks. The first change comes N+2 clocks after the clock edge that performs the data access.
- R3: The clock pin toggles once per timer underflow, so a byte takes 16 toggles. Every bit starts with the pin high, which makes the first toggle of a transfer a falling one.
- R4: In transmit mode, each falling edge of the clock pin drives the register MSB onto dat_pin_o. Bits leave MSB first.
- R5: In transmit mode, each rising edge shifts the register left and loads into the LSB the bit that is on dat_pin_o. After 8 bits the register reads back its starting value.
- R6: In receive mode, each rising edge shifts the register left and loads dat_pin_i into the LSB in the same event. The first bit received ends up in the MSB.
- R7: After the 8th bit the clock pin stays high and does not toggle again until the next data access. Flag bit 0 is set at that point.
- R8: Any read or write of the data register restarts the bit count, clears flag bit 0 and forces the clock pin high. This applies even in the middle of a transfer.
- R9: Writing 1 to flag bit 0 clears it. A flag read returns bit 0 as the raw flag and bit 7 as flag AND enable bit 0. The irq output equals flag AND enable.
- R10: After reset the clock pin is high, both output enables are low, irq is low and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Register access strobe, one cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data (combinational) |
| clk_pin_o | output | 1 | Shift clock level |
| clk_pin_oe | output | 1 | Shift clock drive enable |
| dat_pin_i | input | 1 | Serial data input |
| dat_pin_o | output | 1 | Serial data output |
| dat_pin_oe | output | 1 | Serial data drive enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a restart in the middle of a byte. The bench must land a data write exactly while a transfer is running, and after a fixed number of clock toggles, so that the old bit sequence is dropped and a new one starts with full timing. The bench waits on its own toggle counter until four toggles have passed, then writes a new value. The scoreboard queue is flushed and reloaded with the new byte. The period is checked again from the access edge. A second hard point is that receive sampling happens in the same event as the shift. The bench therefore acts as the remote device: it changes dat_pin_i only just after each falling edge, and expects the received byte to carry the first bit in its MSB.

// File: rtl/timed_shift_port.sv
module timed_shift_port #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          clk_pin_o,
  output logic          clk_pin_oe,
  input  logic          dat_pin_i,
  output logic          dat_pin_o,
  output logic          dat_pin_oe,
  output logic          irq
);
  localparam int BW = $clog2(DW);
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_RATE = AW'(1);
  localparam logic [AW-1:0] A_MODE = AW'(2);
  localparam logic [AW-1:0] A_FLAG = AW'(3);
  localparam logic [AW-1:0] A_EN   = AW'(4);
  localparam logic [BW-1:0] LAST   = BW'(DW - 1);

  logic [DW-1:0] sr_q, rate_q, mode_q, cnt_q;
  logic [BW-1:0] bits_q;
  logic          rl_q, halt_q, cb1_q, cb2_q, flag_q, en_q;

  wire wr   = bus_cs & bus_we;
  wire acc  = bus_cs && (bus_addr == A_DATA);
  wire sin  = (mode_q[4:2] == 3'b001);
  wire sout = (mode_q[4:2] == 3'b101);
  wire run  = (sin | sout) & ~halt_q;
  wire uf   = rl_q & run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rl_q  <= 1'b0;
    end else if (!run || acc || rl_q) begin
      cnt_q <= rate_q;
      rl_q  <= 1'b0;
    end else if (cnt_q == '0) begin
      rl_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      bits_q <= '0;
      halt_q <= 1'b1;
      cb1_q  <= 1'b1;
      cb2_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (acc) begin
        bits_q <= '0;
        halt_q <= 1'b0;
        cb1_q  <= 1'b1;
        flag_q <= 1'b0;
        if (wr) sr_q <= bus_wdata;
      end else if (uf) begin
        cb1_q <= ~cb1_q;
        if (cb1_q) begin
          if (sout) cb2_q <= sr_q[DW-1];
        end else begin
          sr_q   <= {sr_q[DW-2:0], sout ? cb2_q : dat_pin_i};
          bits_q <= bits_q + 1'b1;
          if (bits_q == LAST) begin
            halt_q <= 1'b1;
            flag_q <= 1'b1;
          end
        end
      end
      if (wr && bus_addr == A_FLAG && bus_wdata[0]) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      mode_q <= '0;
      en_q   <= 1'b0;
    end else if (wr) begin
      if (bus_addr == A_RATE) rate_q <= bus_wdata;
      if (bus_addr == A_MODE) mode_q <= bus_wdata;
      if (bus_addr == A_EN)   en_q   <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DATA: bus_rdata = sr_q;
      A_RATE: bus_rdata = rate_q;
      A_MODE: bus_rdata = mode_q;
      A_FLAG: begin
        bus_rdata[DW-1] = flag_q & en_q;
        bus_rdata[0]    = flag_q;
      end
      A_EN:   bus_rdata[0] = en_q;
      default: bus_rdata = '0;
    endcase
  end

  assign clk_pin_o  = cb1_q;
  assign clk_pin_oe = sin | sout;
  assign dat_pin_o  = cb2_q;
  assign dat_pin_oe = sout;
  assign irq        = flag_q & en_q;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!uf && !acc) |=> $stable(cb1_q));
  p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> cb1_q);
  p_msb_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && sout && cb1_q && !acc) |=> (cb2_q == $past(sr_q[DW-1])));
  p_rotate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && sout && !cb1_q && !acc) |=> (sr_q[0] == $past(cb2_q)));
  p_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && sin && !cb1_q && !acc) |=> (sr_q[0] == $past(dat_pin_i)));
  p_flag_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> halt_q);
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (cb1_q && !flag_q));
endmodule

// File: tb/timed_shift_port_test.sv
module timed_shift_port_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_cs = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       clk_pin_o, clk_pin_oe, dat_pin_i = 1'b0, dat_pin_o, dat_pin_oe, irq;

  timed_shift_port uut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, t_ref = 0, toggles = 0, period = 0;
  bit prev_cb1 = 1'b1;
  bit mode_out = 1'b0, mode_in = 1'b0;
  bit exp_q[$];
  logic [7:0] in_pat = '0;
  int in_idx = 0;
  logic [7:0] rv;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_cs = 0; bus_we = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_cs = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_cs = 0;
  endtask

  task automatic push_byte(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) exp_q.push_back(d[i]);
  endtask

  task automatic start(input logic [7:0] d);
    @(negedge clk); bus_cs = 1; bus_we = 1; bus_addr = 3'd0; bus_wdata = d;
    @(negedge clk); bus_cs = 0; bus_we = 0;
    t_ref = cyc; toggles = 0;
  endtask

  // monitor: pops expected transmit bits, drives receive bits, checks period
  always @(negedge clk) begin
    if (rst_n && clk_pin_o !== prev_cb1) begin
      toggles++;
      chk(cyc - t_ref == period, "R2 period", cyc - t_ref, period);
      if (toggles == 1) chk(clk_pin_o == 1'b0, "R3 first edge falls", clk_pin_o, 0);
      if (!clk_pin_o && mode_out) begin
        if (exp_q.size() == 0) chk(0, "R4 unexpected bit", dat_pin_o, 0);
        else begin
          automatic bit e = exp_q.pop_front();
          chk(dat_pin_o == e, "R4 msb out", dat_pin_o, e);
        end
      end
      if (!clk_pin_o && mode_in) begin
        dat_pin_i <= in_pat[7 - in_idx];
        in_idx++;
      end
      t_ref = cyc;
    end
    prev_cb1 = clk_pin_o;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(clk_pin_o == 1, "R10 clk pin high", clk_pin_o, 1);
    chk(clk_pin_oe == 0 && dat_pin_oe == 0, "R10 oe low", {clk_pin_oe, dat_pin_oe}, 0);
    chk(irq == 0, "R10 irq", irq, 0);
    rd_reg(3'd2, rv); chk(rv == 0, "R10 mode zero", rv, 0);

    // transmit, rate 2
    wr_reg(3'd1, 8'd2); period = 4;
    wr_reg(3'd2, 8'h14); mode_out = 1;
    chk(clk_pin_oe && dat_pin_oe, "R1 tx oe", {clk_pin_oe, dat_pin_oe}, 3);
    push_byte(8'hA5); start(8'hA5);
    wait (toggles == 16); repeat (20) @(negedge clk);
    chk(toggles == 16, "R7 no extra toggles", toggles, 16);
    chk(clk_pin_o == 1, "R7 idle high", clk_pin_o, 1);
    chk(exp_q.size() == 0, "R4 all bits out", exp_q.size(), 0);
    rd_reg(3'd3, rv); chk(rv == 8'h01, "R7 flag set", rv, 8'h01);
    rd_reg(3'd0, rv); chk(rv == 8'hA5, "R5 rotated back", rv, 8'hA5);
    wr_reg(3'd2, 8'h00); mode_out = 0;
    rd_reg(3'd3, rv); chk(rv == 8'h00, "R8 access clears flag", rv, 0);
    repeat (20) @(negedge clk);
    chk(toggles == 16, "R1 idle mode no toggles", toggles, 16);
    chk(clk_pin_oe == 0, "R1 idle oe", clk_pin_oe, 0);

    // receive, rate 3
    wr_reg(3'd1, 8'd3); period = 5;
    wr_reg(3'd4, 8'h01);
    wr_reg(3'd2, 8'h04); mode_in = 1; in_pat = 8'h3C; in_idx = 0;
    chk(clk_pin_oe && !dat_pin_oe, "R1 rx oe", {clk_pin_oe, dat_pin_oe}, 2);
    start(8'h00);
    wait (toggles == 16); repeat (10) @(negedge clk);
    chk(irq == 1, "R9 irq raised", irq, 1);
    rd_reg(3'd3, rv); chk(rv == 8'h81, "R9 flag read", rv, 8'h81);
    wr_reg(3'd3, 8'hFF);
    chk(irq == 0, "R9 write ones clears", irq, 0);
    wr_reg(3'd2, 8'h00); mode_in = 0;
    rd_reg(3'd0, rv); chk(rv == 8'h3C, "R6 received byte", rv, 8'h3C);

    // restart mid transfer, rate 1
    wr_reg(3'd1, 8'd1); period = 3;
    wr_reg(3'd2, 8'h14); mode_out = 1;
    push_byte(8'hF0); start(8'hF0);
    wait (toggles == 4);
    exp_q.delete(); push_byte(8'h5A); start(8'h5A);
    chk(irq == 0, "R8 no flag mid byte", irq, 0);
    wait (toggles == 16); repeat (10) @(negedge clk);
    chk(toggles == 16 && exp_q.size() == 0, "R8 full byte after restart", toggles, 16);
    chk(irq == 1, "R8 flag after restart", irq, 1);

    // rate 0
    wr_reg(3'd1, 8'd0); period = 2;
    push_byte(8'h81); start(8'h81);
    wait (toggles == 16); repeat (10) @(negedge clk);
    chk(clk_pin_o == 1, "R7 idle high fast", clk_pin_o, 1);
    wr_reg(3'd2, 8'h00); mode_out = 0;
    rd_reg(3'd0, rv); chk(rv == 8'h81, "R5 rotated fast", rv, 8'h81);

    // enable gating: flag cleared by that read, make a new one
    wr_reg(3'd2, 8'h14); mode_out = 1;
    push_byte(8'h42); start(8'h42);
    wait (toggles == 16); repeat (10) @(negedge clk);
    wr_reg(3'd4, 8'h00);
    chk(irq == 0, "R9 enable off", irq, 0);
    rd_reg(3'd3, rv); chk(rv == 8'h01, "R9 raw flag kept", rv, 8'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule